// File: doc/BRIEF.md
# Fixed-Region Harvard Memory Protection Check

This block sits between address translation and the memory system and decides whether a physical access may proceed. Every request carries a physical address, an access kind (instruction fetch, data load or data store), the privilege of the requester and the current lock state of instruction memory. The block compares the address with three fixed windows: instruction memory (which also covers the instruction ROM), data memory and the memory-mapped I/O window. It then returns one verdict: either the access is allowed, or it is refused with a single trap cause.

Instructions and data stay strictly apart. Code may only be fetched from instruction memory, and only after that memory has been locked. Loads and stores may never reach instruction memory, and fetches may never reach data memory. The I/O window is reachable by supervisor loads and stores only. Those accesses are tagged with an I/O marker so that later stages can treat them as uncached and strictly ordered.

The decision is purely combinational and has no clock, no reset and no stored state. The house-style state register therefore has no counterpart here. The one decision process is written as a `unique case` over the access class, and each of its arms is listed in the requirements below. The window bounds are parameters.

Top module: `harvard_mpu`

## Requirements
- R1: With default parameters the windows are: instruction memory at bytes 0x00000000..0x000003FF (256 words at base 0), data memory at bytes 0x00000400..0x000013FF (1024 words at 0x400), and I/O at bytes 0xFFFF0000..0xFFFF00FF. Both ends of each window are inside it, and the windows never overlap.
- R2: The access kind is encoded as 0 = fetch, 1 = load, 2 = store; code 3 is handled exactly like a load. `is_user` = 1 marks a user-level request and 0 marks supervisor.
- R3: A fetch inside instruction memory while `imem_locked` = 1 is allowed, with cause 0, for either privilege.
- R4: A fetch inside instruction memory while `imem_locked` = 0 is refused with cause 1 (fetch access fault).
- R5: A fetch inside data memory is refused with cause 24 (Harvard violation), whatever the lock state.
- R6: A load or store inside instruction memory is refused with cause 24, whatever the lock state and privilege.
- R7: A load or store inside data memory is allowed for either privilege, and `mmio_hit` stays 0.
- R8: A supervisor load or store inside the I/O window is allowed and drives `mmio_hit` = 1.
- R9: A user load inside the I/O window is refused with cause 5 (load access fault). A user store there is refused with cause 7 (store access fault).
- R10: An address outside all windows gives cause 1 for a fetch, 5 for a load and 7 for a store. A fetch inside the I/O window also gives cause 1.
- R11: Each request produces exactly one outcome. `allow` = 1 exactly when `cause` = 0. `mmio_hit` is 1 only on an allowed access. The outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phys_addr | input | 32 | Physical byte address after translation |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 treated as load |
| is_user | input | 1 | 1 = user privilege, 0 = supervisor |
| imem_locked | input | 1 | 1 = instruction memory locked and executable |
| allow | output | 1 | Access may proceed |
| mmio_hit | output | 1 | Allowed access targets the I/O window |
| cause | output | 5 | Trap cause, 0 when allowed |

## Verification
The check is tried with each access kind in each window: instruction memory, data memory, the I/O window, and the gaps between and beyond them. Each combination is tried with both privilege levels and both lock states, so that an arm of the decision answering for the wrong kind, privilege or lock state shows up as a wrong cause. The first and last byte of every window, and the bytes just outside them, are probed to tell an off-by-one bound from a correct one. Stores are kept apart from loads, and the reserved kind code is kept apart from a real load, so that a wrong fault code for the access kind is caught.

// File: rtl/hmpu_pkg.sv
package hmpu_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int CAUSE_W = 5;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE        = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_FAULT = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD_FAULT  = 5'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE_FAULT = 5'd7;
    localparam logic [CAUSE_W-1:0] CAUSE_HARVARD     = 5'd24;

    localparam int NUM_RG  = 3;
    localparam int RG_IMEM = 0;
    localparam int RG_DMEM = 1;
    localparam int RG_MMIO = 2;

    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/hmpu_range.sv
module hmpu_range #(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter logic [ADDR_W:0]   BYTES  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [ADDR_W:0] offset;

    always_comb begin
        offset = {1'b0, addr} - {1'b0, BASE};
        hit    = (addr >= BASE) && (offset < BYTES);
    end

endmodule

// File: rtl/hmpu_policy.sv
module hmpu_policy
    import hmpu_pkg::*;
(
    input  logic [NUM_RG-1:0]  rg_hit,
    input  acc_e               kind,
    input  logic               is_user,
    input  logic               imem_locked,
    output logic               allow,
    output logic               mmio_hit,
    output logic [CAUSE_W-1:0] cause
);

    logic [CAUSE_W-1:0] data_fault;

    always_comb begin
        data_fault = (kind == ACC_STORE) ? CAUSE_STORE_FAULT : CAUSE_LOAD_FAULT;
        mmio_hit   = 1'b0;
        cause      = CAUSE_NONE;
        unique case (kind)
            ACC_FETCH: begin
                if (rg_hit[RG_IMEM])
                    cause = imem_locked ? CAUSE_NONE : CAUSE_FETCH_FAULT;
                else if (rg_hit[RG_DMEM])
                    cause = CAUSE_HARVARD;
                else
                    cause = CAUSE_FETCH_FAULT;
            end
            ACC_LOAD, ACC_STORE, ACC_RSVD: begin
                if (rg_hit[RG_IMEM])
                    cause = CAUSE_HARVARD;
                else if (rg_hit[RG_DMEM])
                    cause = CAUSE_NONE;
                else if (rg_hit[RG_MMIO] && !is_user) begin
                    cause    = CAUSE_NONE;
                    mmio_hit = 1'b1;
                end else
                    cause = data_fault;
            end
            default: cause = CAUSE_LOAD_FAULT;
        endcase
        allow = (cause == CAUSE_NONE);
    end

endmodule

// File: rtl/harvard_mpu.sv
module harvard_mpu
    import hmpu_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] IMEM_BASE  = 32'h0000_0000,
    parameter int                IMEM_WORDS = 256,
    parameter logic [ADDR_W-1:0] DMEM_BASE  = 32'h0000_0400,
    parameter int                DMEM_WORDS = 1024,
    parameter logic [ADDR_W-1:0] MMIO_BASE  = 32'hFFFF_0000,
    parameter int                MMIO_BYTES = 256
) (
    input  logic [ADDR_W-1:0]  phys_addr,
    input  logic [1:0]         acc_kind,
    input  logic               is_user,
    input  logic               imem_locked,
    output logic               allow,
    output logic               mmio_hit,
    output logic [CAUSE_W-1:0] cause
);

    localparam logic [ADDR_W:0] IMEM_SPAN = (ADDR_W+1)'(IMEM_WORDS * WORD_BYTES);
    localparam logic [ADDR_W:0] DMEM_SPAN = (ADDR_W+1)'(DMEM_WORDS * WORD_BYTES);
    localparam logic [ADDR_W:0] MMIO_SPAN = (ADDR_W+1)'(MMIO_BYTES);

    logic [NUM_RG-1:0] rg_hit;
    acc_e              kind;

    assign kind = acc_e'(acc_kind);

    for (genvar gi = 0; gi < NUM_RG; gi++) begin : g_rg
        localparam logic [ADDR_W-1:0] RB = (gi == RG_IMEM) ? IMEM_BASE :
                                           (gi == RG_DMEM) ? DMEM_BASE : MMIO_BASE;
        localparam logic [ADDR_W:0]   RS = (gi == RG_IMEM) ? IMEM_SPAN :
                                           (gi == RG_DMEM) ? DMEM_SPAN : MMIO_SPAN;
        hmpu_range #(
            .ADDR_W (ADDR_W),
            .BASE   (RB),
            .BYTES  (RS)
        ) u_range (
            .addr (phys_addr),
            .hit  (rg_hit[gi])
        );
    end

    hmpu_policy u_policy (
        .rg_hit      (rg_hit),
        .kind        (kind),
        .is_user     (is_user),
        .imem_locked (imem_locked),
        .allow       (allow),
        .mmio_hit    (mmio_hit),
        .cause       (cause)
    );

    always_comb begin
        AST_REGIONS_DISJOINT: assert ($onehot0(rg_hit)); // R1
        AST_ONE_OUTCOME: assert (allow == (cause == CAUSE_NONE)); // R11
        if (mmio_hit) begin
            AST_MMIO_TAG: assert (allow && rg_hit[RG_MMIO] && !is_user && kind != ACC_FETCH); // R8
        end
        if (rg_hit[RG_IMEM] && kind != ACC_FETCH) begin
            AST_DATA_INTO_IMEM: assert (cause == CAUSE_HARVARD); // R6
        end
        if (rg_hit[RG_DMEM] && kind == ACC_FETCH) begin
            AST_FETCH_FROM_DMEM: assert (cause == CAUSE_HARVARD); // R5
        end
        if (rg_hit[RG_IMEM] && kind == ACC_FETCH && !imem_locked) begin
            AST_UNLOCKED_FETCH: assert (cause == CAUSE_FETCH_FAULT); // R4
        end
        if (rg_hit[RG_MMIO] && is_user && kind != ACC_FETCH) begin
            AST_USER_IO_DENIED: assert (!allow && !mmio_hit); // R9
        end
    end

endmodule

// File: tb/sim_harvard_mpu.sv
module sim_harvard_mpu;

    logic        clk = 1'b0;
    logic [31:0] phys_addr = '0;
    logic [1:0]  acc_kind = 2'd0;
    logic        is_user = 1'b0;
    logic        imem_locked = 1'b0;
    logic        allow;
    logic        mmio_hit;
    logic [4:0]  cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    localparam logic [1:0] K_F = 2'd0, K_L = 2'd1, K_S = 2'd2, K_R = 2'd3;

    always #10 clk = ~clk;

    harvard_mpu u0 (
        .phys_addr   (phys_addr),
        .acc_kind    (acc_kind),
        .is_user     (is_user),
        .imem_locked (imem_locked),
        .allow       (allow),
        .mmio_hit    (mmio_hit),
        .cause       (cause)
    );

    task automatic probe(input string req, input logic [31:0] a, input logic [1:0] k,
                         input logic u, input logic lk,
                         input logic e_allow, input logic e_mmio, input logic [4:0] e_cause);
        @(negedge clk);
        phys_addr = a; acc_kind = k; is_user = u; imem_locked = lk;
        #5;
        n_checks++;
        if (allow !== e_allow || mmio_hit !== e_mmio || cause !== e_cause) begin
            n_fails++;
            $display("FAIL %s addr=%h kind=%0d user=%0d lock=%0d: got allow=%0b mmio=%0b cause=%0d, expected allow=%0b mmio=%0b cause=%0d",
                     req, a, k, u, lk, allow, mmio_hit, cause, e_allow, e_mmio, e_cause);
        end
    endtask

    task automatic t_idle;
        #5;
        n_checks++;
        if (allow !== 1'b0 || cause !== 5'd1 || mmio_hit !== 1'b0) begin
            n_fails++;
            $display("FAIL R4 idle: got allow=%0b mmio=%0b cause=%0d, expected allow=0 mmio=0 cause=1",
                     allow, mmio_hit, cause);
        end
    endtask

    task automatic t_fetch_locked; // R3
        probe("R3", 32'h0000_0000, K_F, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0);
        probe("R3", 32'h0000_03FC, K_F, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0);
        probe("R3", 32'h0000_0123, K_F, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0);
    endtask

    task automatic t_fetch_unlocked; // R4
        probe("R4", 32'h0000_0000, K_F, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1);
        probe("R4", 32'h0000_03FF, K_F, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1);
    endtask

    task automatic t_fetch_dmem; // R5
        probe("R5", 32'h0000_0400, K_F, 1'b0, 1'b1, 1'b0, 1'b0, 5'd24);
        probe("R5", 32'h0000_13FF, K_F, 1'b1, 1'b0, 1'b0, 1'b0, 5'd24);
    endtask

    task automatic t_data_imem; // R6
        probe("R6", 32'h0000_0000, K_L, 1'b0, 1'b1, 1'b0, 1'b0, 5'd24);
        probe("R6", 32'h0000_03FF, K_S, 1'b1, 1'b0, 1'b0, 1'b0, 5'd24);
        probe("R6", 32'h0000_0200, K_S, 1'b0, 1'b0, 1'b0, 1'b0, 5'd24);
    endtask

    task automatic t_data_dmem; // R7
        probe("R7", 32'h0000_0400, K_L, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0);
        probe("R7", 32'h0000_13FF, K_S, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0);
        probe("R7", 32'h0000_0800, K_S, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0);
    endtask

    task automatic t_io_super; // R8
        probe("R8", 32'hFFFF_0000, K_L, 1'b0, 1'b0, 1'b1, 1'b1, 5'd0);
        probe("R8", 32'hFFFF_00FF, K_S, 1'b0, 1'b1, 1'b1, 1'b1, 5'd0);
    endtask

    task automatic t_io_user; // R9
        probe("R9", 32'hFFFF_0010, K_L, 1'b1, 1'b0, 1'b0, 1'b0, 5'd5);
        probe("R9", 32'hFFFF_00FF, K_S, 1'b1, 1'b1, 1'b0, 1'b0, 5'd7);
    endtask

    task automatic t_outside; // R10
        probe("R10", 32'h0000_1400, K_L, 1'b0, 1'b1, 1'b0, 1'b0, 5'd5);
        probe("R10", 32'h0000_1400, K_S, 1'b0, 1'b1, 1'b0, 1'b0, 5'd7);
        probe("R10", 32'h0000_1400, K_F, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1);
        probe("R10", 32'hFFFE_FFFF, K_S, 1'b0, 1'b1, 1'b0, 1'b0, 5'd7);
        probe("R10", 32'hFFFF_0100, K_L, 1'b0, 1'b1, 1'b0, 1'b0, 5'd5);
        probe("R10", 32'hFFFF_0040, K_F, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1);
    endtask

    task automatic t_reserved_kind; // R2
        probe("R2", 32'h0000_0500, K_R, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0);
        probe("R2", 32'hFFFF_0004, K_R, 1'b1, 1'b0, 1'b0, 1'b0, 5'd5);
        probe("R2", 32'hFFFF_0004, K_R, 1'b0, 1'b0, 1'b1, 1'b1, 5'd0);
    endtask

    task automatic t_bounds; // R1 and R11
        probe("R1", 32'h0000_03FF, K_L, 1'b0, 1'b1, 1'b0, 1'b0, 5'd24);
        probe("R1", 32'h0000_0400, K_L, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0);
        probe("R11", 32'h0000_0400, K_F, 1'b0, 1'b1, 1'b0, 1'b0, 5'd24);
        probe("R11", 32'h0000_0000, K_F, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        t_idle();
        t_fetch_locked();
        t_fetch_unlocked();
        t_fetch_dmem();
        t_data_imem();
        t_data_dmem();
        t_io_super();
        t_io_user();
        t_outside();
        t_reserved_kind();
        t_bounds();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule